// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It samples the line on every cycle of a clock that runs at sixteen times the bit rate. A falling edge on the idle line starts a character. Each bit after that is taken once at its midpoint. When the character is complete, it moves into a parallel holding register. Four status flags report on it: data ready, parity error, framing error and overrun.

The character format comes from a latched control word: data length of 5 to 8 bits, whether a parity bit is present, and whether parity is even or odd. While the load input is high the control register follows its inputs. When the load input falls, the register keeps the word it holds. The host clears the data-ready flag by driving a strobe low. Two separate disable inputs float the data outputs and the status outputs, so several receivers can share one host bus. A synchronous master reset clears the flags and leaves the held character in place.

Top module: `async_char_receiver`

## Requirements
- R1: A high-to-low change on `rx_line` while idle starts a character. The line is checked again 8 sample clocks later. If it is high at that point, the start is dropped as a glitch and no character is produced.
- R2: `cfg_len` sets the data length, with bit 1 as the most significant: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data arrives least significant bit first and is stored right-justified from bit 0. Unused upper bits of `rx_data` read 0.
- R3: When parity is enabled (`cfg_par_off` = 0), a parity bit follows the data. `cfg_par_even` = 1 expects an even count of ones over the data and parity bits; 0 expects an odd count. `parity_err` is high after a character whose count does not match.
- R4: When parity is inhibited, no parity bit is expected and `parity_err` stays low.
- R5: `frame_err` is high after a character whose first stop bit was sampled low. Only the first stop bit is judged.
- R6: `data_ready` goes high once a character is moved into the holding register. A low level on `rdy_clear_n` forces it low, and clearing takes priority over a transfer in the same cycle.
- R7: `overrun_err` goes high when a character is transferred while `data_ready` is still high and no clear is asserted in that cycle. Each transfer updates `overrun_err`, `parity_err` and `frame_err`.
- R8: `rst` high clears all four flags on the next clock. It does not change the holding register.
- R9: `data_hiz` = 1 floats `rx_data`. `status_hiz` = 1 floats the four flag outputs. The two disables act independently of each other.
- R10: The control register follows `cfg_len`, `cfg_par_off` and `cfg_par_even` while `cfg_load` is high, and holds its value while `cfg_load` is low. Each character uses the format held at the moment its start edge is detected.
- R11: After the first stop bit is sampled, the receiver hunts for the next start edge immediately. Characters sent back to back with a single stop bit are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 times the bit rate |
| rst | input | 1 | Synchronous master reset, active high |
| rx_line | input | 1 | Serial input line, idle high |
| cfg_load | input | 1 | Control register load; transparent while high |
| cfg_len | input | 2 | Data length select |
| cfg_par_off | input | 1 | 1 = no parity bit |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rdy_clear_n | input | 1 | Active-low clear of data_ready |
| data_hiz | input | 1 | 1 = rx_data floats |
| status_hiz | input | 1 | 1 = status flags float |
| rx_data | output | 8 | Holding register, right-justified |
| parity_err | output | 1 | Parity mismatch on the last character |
| frame_err | output | 1 | First stop bit of the last character was low |
| overrun_err | output | 1 | Last character overwrote an unread one |
| data_ready | output | 1 | A character is waiting in the holding register |

## Verification
The hardest cases to reach from the ports depend on exact timing: a character that completes while the host is still reading the previous one, and a start pulse that ends just before the mid-bit recheck. The bench sends frames bit by bit on the 16-clock grid and leaves the previous character unread, so two frames arrive back to back and force an overrun. It also drives a short low pulse of four sample clocks to test glitch rejection. A behavioural model collects line samples at the computed mid-bit instants. It predicts every flag and the held data on every clock, so a result that arrives one cycle early or late is also caught.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int MAX_BITS = 8;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_off;
        logic       par_even;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{len_sel: 2'b11, par_off: 1'b1, par_even: 1'b0};

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic                valid;
        logic [MAX_BITS-1:0] data;
        logic                par_en;
        logic                par_bad;
        logic                frame_bad;
    } char_t;

    function automatic logic [2:0] last_bit_index(input logic [1:0] sel);
        return 3'd4 + {1'b0, sel};
    endfunction

    function automatic logic parity_mismatch(input logic [MAX_BITS-1:0] data,
                                             input logic pbit, input ctrl_t c);
        logic ones_odd;
        ones_odd = (^data) ^ pbit;
        return !c.par_off && (ones_odd ^ !c.par_even);
    endfunction

endpackage

// File: rtl/rxc_ctrl_reg.sv
module rxc_ctrl_reg
    import rxc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  ctrl_t word_in,
    output ctrl_t word_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= CTRL_DEFAULT;
        end else if (load) begin
            word_q <= word_in;
        end
    end

endmodule

// File: rtl/rxc_framer.sv
module rxc_framer
    import rxc_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rx_line,
    input  ctrl_t ctrl,
    output char_t done
);

    localparam int CW = $clog2(OVERSAMPLE + 1);
    localparam logic [CW-1:0] MID_CNT  = CW'(OVERSAMPLE / 2);
    localparam logic [CW-1:0] FULL_CNT = CW'(OVERSAMPLE);

    logic                line_q;
    logic                line_d;
    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [2:0]          idx;
    ctrl_t               fc;
    logic [MAX_BITS-1:0] shreg;
    logic                pbit;
    logic                tick;

    assign tick = (state == RX_START) ? (cnt == MID_CNT) : (cnt == FULL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b1;
            line_d <= 1'b1;
            state  <= RX_HUNT;
            cnt    <= '0;
            idx    <= '0;
            fc     <= CTRL_DEFAULT;
            shreg  <= '0;
            pbit   <= 1'b0;
            done   <= '0;
        end else begin
            line_q     <= rx_line;
            line_d     <= line_q;
            done.valid <= 1'b0;
            if (state != RX_HUNT) begin
                cnt <= tick ? CW'(1) : cnt + 1'b1;
            end
            case (state)
                RX_HUNT: begin
                    if (line_d && !line_q) begin
                        state <= RX_START;
                        cnt   <= CW'(1);
                        fc    <= ctrl;
                        shreg <= '0;
                        idx   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        state <= line_q ? RX_HUNT : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        shreg[idx] <= line_q;
                        idx        <= idx + 1'b1;
                        if (idx == last_bit_index(fc.len_sel)) begin
                            state <= fc.par_off ? RX_STOP : RX_PARITY;
                        end
                    end
                end
                RX_PARITY: begin
                    if (tick) begin
                        pbit  <= line_q;
                        state <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        state <= RX_HUNT;
                        done  <= '{valid:     1'b1,
                                   data:      shreg,
                                   par_en:    !fc.par_off,
                                   par_bad:   parity_mismatch(shreg, pbit, fc),
                                   frame_bad: !line_q};
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/rxc_status_hold.sv
module rxc_status_hold
    import rxc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  char_t               done,
    input  logic                rdy_clear_n,
    output logic [MAX_BITS-1:0] hold,
    output logic                dr,
    output logic                pe,
    output logic                fe,
    output logic                oe
);

    always_ff @(posedge clk) begin
        if (done.valid) begin
            hold <= done.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dr <= 1'b0;
            pe <= 1'b0;
            fe <= 1'b0;
            oe <= 1'b0;
        end else begin
            if (done.valid) begin
                pe <= done.par_en & done.par_bad;
                fe <= done.frame_bad;
                oe <= dr & rdy_clear_n;
            end
            if (!rdy_clear_n) begin
                dr <= 1'b0;
            end else if (done.valid) begin
                dr <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/async_char_receiver.sv
module async_char_receiver
    import rxc_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_line,
    input  logic       cfg_load,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_off,
    input  logic       cfg_par_even,
    input  logic       rdy_clear_n,
    input  logic       data_hiz,
    input  logic       status_hiz,
    output logic [7:0] rx_data,
    output logic       parity_err,
    output logic       frame_err,
    output logic       overrun_err,
    output logic       data_ready
);

    ctrl_t               ctrl_q;
    char_t               done_w;
    logic [MAX_BITS-1:0] hold_q;
    logic                dr_q;
    logic                pe_q;
    logic                fe_q;
    logic                oe_q;

    rxc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .word_in ('{len_sel: cfg_len, par_off: cfg_par_off, par_even: cfg_par_even}),
        .word_q  (ctrl_q)
    );

    rxc_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .rx_line (rx_line),
        .ctrl    (ctrl_q),
        .done    (done_w)
    );

    rxc_status_hold u_status (
        .clk         (clk),
        .rst         (rst),
        .done        (done_w),
        .rdy_clear_n (rdy_clear_n),
        .hold        (hold_q),
        .dr          (dr_q),
        .pe          (pe_q),
        .fe          (fe_q),
        .oe          (oe_q)
    );

    assign rx_data     = data_hiz   ? 8'bzzzz_zzzz : hold_q;
    assign data_ready  = status_hiz ? 1'bz : dr_q;
    assign parity_err  = status_hiz ? 1'bz : pe_q;
    assign frame_err   = status_hiz ? 1'bz : fe_q;
    assign overrun_err = status_hiz ? 1'bz : oe_q;

endmodule

// File: rtl/rxc_checker.sv
module rxc_checker
    import rxc_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  rdy_clear_n,
    input char_t done,
    input logic  dr,
    input logic  pe,
    input logic  fe,
    input logic  oe
);

    // R6: a low clear strobe leaves data-ready low after the edge
    a_r6_clear_forces_low: assert property (@(posedge clk) disable iff (rst)
        !rdy_clear_n |=> !dr);

    // R6: a transfer without clear raises data-ready
    a_r6_transfer_sets_ready: assert property (@(posedge clk) disable iff (rst)
        (done.valid && rdy_clear_n) |=> dr);

    // R7: a transfer onto unread data flags overrun
    a_r7_overrun_flagged: assert property (@(posedge clk) disable iff (rst)
        (done.valid && dr && rdy_clear_n) |=> oe);

    // R4: a character without parity never raises the parity flag
    a_r4_no_parity_flag: assert property (@(posedge clk) disable iff (rst)
        (done.valid && !done.par_en) |=> !pe);

    // R5: the framing flag follows the stop-bit verdict of the transferred character
    a_r5_frame_follows_stop: assert property (@(posedge clk) disable iff (rst)
        done.valid |=> (fe == $past(done.frame_bad)));

    // R8: master reset clears every flag
    a_r8_reset_clears_flags: assert property (@(posedge clk)
        rst |=> (!dr && !pe && !fe && !oe));

endmodule

bind async_char_receiver rxc_checker u_rxc_checker (
    .clk         (clk),
    .rst         (rst),
    .rdy_clear_n (rdy_clear_n),
    .done        (done_w),
    .dr          (dr_q),
    .pe          (pe_q),
    .fe          (fe_q),
    .oe          (oe_q)
);

// File: tb/test_async_char_receiver.sv
`timescale 1ns/1ps
module test_async_char_receiver;

    localparam int BT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       cfg_load = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_off = 1'b1;
    logic       cfg_par_even = 1'b0;
    logic       rdy_clear_n = 1'b1;
    logic       data_hiz = 1'b0;
    logic       status_hiz = 1'b0;
    wire  [7:0] rx_data_w;
    wire        pe_w;
    wire        fe_w;
    wire        oe_w;
    wire        dr_w;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_run = 1'b0;

    always #5 clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (rx_data_w[i]);
    end
    pullup (pe_w);
    pullup (fe_w);
    pullup (oe_w);
    pullup (dr_w);

    async_char_receiver i_async_char_receiver (
        .clk          (clk),
        .rst          (rst),
        .rx_line      (rx_line),
        .cfg_load     (cfg_load),
        .cfg_len      (cfg_len),
        .cfg_par_off  (cfg_par_off),
        .cfg_par_even (cfg_par_even),
        .rdy_clear_n  (rdy_clear_n),
        .data_hiz     (data_hiz),
        .status_hiz   (status_hiz),
        .rx_data      (rx_data_w),
        .parity_err   (pe_w),
        .frame_err    (fe_w),
        .overrun_err  (oe_w),
        .data_ready   (dr_w)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit         m_started = 1'b0;
    bit         m_prev = 1'b1;
    bit         m_busy = 1'b0;
    int         m_t = 0;
    int         m_pend = 0;
    int         m_len_sel = 3;
    bit         m_poff = 1'b1;
    bit         m_peven = 1'b0;
    int         f_len = 8;
    bit         f_poff = 1'b1;
    bit         f_peven = 1'b0;
    bit         bitq[$];
    bit         m_dr = 0, m_pe = 0, m_fe = 0, m_oe = 0;
    logic [7:0] m_hold = 8'h00;
    bit         m_hold_ok = 1'b0;
    logic [7:0] n_data = 8'h00;
    bit         n_pe = 0, n_fe = 0;

    always @(posedge clk) begin
        bit fire;
        if (rst) begin
            m_started = 1'b1;
            m_dr = 0; m_pe = 0; m_fe = 0; m_oe = 0;
            m_busy = 0; m_pend = 0; m_prev = 1;
            m_len_sel = 3; m_poff = 1; m_peven = 0;
        end else begin
            if (cfg_load) begin
                m_len_sel = int'(cfg_len); m_poff = cfg_par_off; m_peven = cfg_par_even;
            end
            fire = (m_pend == 1);
            if (m_pend > 0) m_pend--;
            if (fire) begin
                m_oe = m_dr && rdy_clear_n;
                m_pe = n_pe; m_fe = n_fe; m_hold = n_data; m_hold_ok = 1'b1;
            end
            if (!rdy_clear_n) m_dr = 0;
            else if (fire) m_dr = 1;
            if (!m_busy) begin
                if (m_prev && !rx_line) begin
                    m_busy = 1; m_t = 0; bitq.delete();
                    f_len = m_len_sel + 5; f_poff = m_poff; f_peven = m_peven;
                end
            end else begin
                m_t++;
                if (m_t >= 8 && (m_t - 8) % BT == 0) begin
                    bitq.push_back(rx_line);
                    if (bitq.size() == 1 && rx_line) begin
                        m_busy = 0;
                    end else if (bitq.size() == 2 + f_len + (f_poff ? 0 : 1)) begin
                        int ones;
                        n_data = 8'h00; ones = 0;
                        for (int k = 0; k < f_len; k++) begin
                            n_data[k] = bitq[1 + k];
                            ones += int'(bitq[1 + k]);
                        end
                        if (f_poff) n_pe = 0;
                        else begin
                            ones += int'(bitq[1 + f_len]);
                            n_pe = f_peven ? (ones % 2 == 1) : (ones % 2 == 0);
                        end
                        n_fe = !bitq[bitq.size() - 1];
                        m_pend = 2;
                        m_busy = 0;
                    end
                end
            end
            m_prev = rx_line;
        end
        #2;
        if (m_started && !done_run) begin
            chk("R6 data_ready", {7'd0, dr_w}, {7'd0, status_hiz ? 1'b1 : m_dr});
            chk("R3 parity_err", {7'd0, pe_w}, {7'd0, status_hiz ? 1'b1 : m_pe});
            chk("R5 frame_err", {7'd0, fe_w}, {7'd0, status_hiz ? 1'b1 : m_fe});
            chk("R7 overrun_err", {7'd0, oe_w}, {7'd0, status_hiz ? 1'b1 : m_oe});
            if (data_hiz) chk("R9 rx_data float", rx_data_w, 8'hFF);
            else if (m_hold_ok) chk("R2 rx_data", rx_data_w, m_hold);
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BT) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input int nb, input bit pen, input bit even,
                             input bit flip, input bit stop_v, input int gap);
        int ones;
        logic pb;
        ones = 0;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive_bit(d[i]);
            ones += int'(d[i]);
        end
        if (pen) begin
            pb = even ? logic'(ones % 2) : logic'(1 - ones % 2);
            drive_bit(flip ? ~pb : pb);
        end
        drive_bit(stop_v);
        if (!stop_v) drive_bit(1'b1);
        repeat (gap) drive_bit(1'b1);
    endtask

    task automatic clear_ready();
        rdy_clear_n = 1'b0;
        @(negedge clk);
        rdy_clear_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_fmt(input logic [1:0] l, input bit poff, input bit even);
        cfg_len = l; cfg_par_off = poff; cfg_par_even = even;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_run) begin
            done_run = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: flags clear after reset
        chk("R8 reset flags", {4'd0, dr_w, pe_w, fe_w, oe_w}, 8'h00);

        // R2/R4/R6: 8 bits, no parity
        send_char(8'hA5, 8, 0, 0, 0, 1, 1);
        chk("R2 8-bit data", rx_data_w, 8'hA5);
        chk("R6 ready set", {7'd0, dr_w}, 8'h01);
        chk("R4 no parity flag", {7'd0, pe_w}, 8'h00);
        clear_ready();
        chk("R6 ready cleared", {7'd0, dr_w}, 8'h00);

        // R2/R3: 5 bits even parity, upper bits ignored
        set_fmt(2'b00, 0, 1);
        send_char(8'hFB, 5, 1, 1, 0, 1, 1);
        chk("R2 5-bit right-justified", rx_data_w, 8'h1B);
        chk("R3 good even parity", {7'd0, pe_w}, 8'h00);
        clear_ready();
        send_char(8'h1B, 5, 1, 1, 1, 1, 1);
        chk("R3 bad even parity", {7'd0, pe_w}, 8'h01);
        clear_ready();

        // R3: 7 bits odd parity, 6 bits even
        set_fmt(2'b10, 0, 0);
        send_char(8'h55, 7, 1, 0, 0, 1, 1);
        chk("R2 7-bit data", rx_data_w, 8'h55);
        chk("R3 good odd parity", {7'd0, pe_w}, 8'h00);
        clear_ready();
        send_char(8'h2C, 7, 1, 0, 1, 1, 1);
        chk("R3 bad odd parity", {7'd0, pe_w}, 8'h01);
        clear_ready();
        set_fmt(2'b01, 0, 1);
        send_char(8'h3A, 6, 1, 1, 0, 1, 1);
        chk("R2 6-bit data", rx_data_w, 8'h3A);
        clear_ready();

        // R5: bad first stop bit, then good one
        set_fmt(2'b11, 1, 0);
        send_char(8'h81, 8, 0, 0, 0, 0, 1);
        chk("R5 framing error", {7'd0, fe_w}, 8'h01);
        clear_ready();
        send_char(8'h7E, 8, 0, 0, 0, 1, 1);
        chk("R5 framing clear", {7'd0, fe_w}, 8'h00);
        clear_ready();

        // R7/R11: back to back, single stop, unread
        send_char(8'h12, 8, 0, 0, 0, 1, 0);
        send_char(8'h34, 8, 0, 0, 0, 1, 1);
        chk("R11 second char received", rx_data_w, 8'h34);
        chk("R7 overrun set", {7'd0, oe_w}, 8'h01);
        clear_ready();
        send_char(8'h56, 8, 0, 0, 0, 1, 1);
        chk("R7 overrun cleared", {7'd0, oe_w}, 8'h00);

        // R1: start glitch discarded, ready stays high
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BT) @(negedge clk);
        chk("R1 glitch data unchanged", rx_data_w, 8'h56);
        chk("R1 glitch no overrun", {7'd0, oe_w}, 8'h00);
        clear_ready();

        // R10: control held while load low
        set_fmt(2'b00, 0, 1);
        cfg_load = 1'b0;
        set_fmt(2'b11, 1, 0);
        send_char(8'h0D, 5, 1, 1, 0, 1, 1);
        chk("R10 held format data", rx_data_w, 8'h0D);
        chk("R10 held format parity", {7'd0, pe_w}, 8'h00);
        cfg_load = 1'b1;
        @(negedge clk);

        // R8: reset keeps holding register
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 flags after reset", {4'd0, dr_w, pe_w, fe_w, oe_w}, 8'h00);
        chk("R8 hold kept", rx_data_w, 8'h0D);

        // R9: independent float controls
        data_hiz = 1'b1;
        @(negedge clk);
        chk("R9 data floats", rx_data_w, 8'hFF);
        chk("R9 status driven", {4'd0, dr_w, pe_w, fe_w, oe_w}, 8'h00);
        data_hiz = 1'b0;
        status_hiz = 1'b1;
        @(negedge clk);
        chk("R9 status floats", {4'd0, dr_w, pe_w, fe_w, oe_w}, 8'h0F);
        chk("R9 data driven", rx_data_w, 8'h0D);
        status_hiz = 1'b0;
        repeat (4) @(negedge clk);

        done_run = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule